// File: doc/BRIEF.md
# Coprocessor Control and Interrupt Register

This block sits on a host's 32-bit register bus and manages two attached coprocessors. A single control word drives, for each coprocessor, a reset line, a power-down request, a level interrupt, an edge interrupt and two programmable-flag interrupts. The same word also shows the power-down acknowledge that comes back from that coprocessor. The edge interrupt is a line that changes state each time software writes a 1 to its bit. The level interrupt, the flags, the power-down request and the reset simply hold the last value written.

Flags that the coprocessors raise toward the host pass through a two-flop synchronizer. They are then compared against a polarity bit for each coprocessor and caught in sticky bits, which software clears by writing 1. There are two return registers with the same layout: one for the ordinary flag returns and one for the programmable-flag returns. The OR of every sticky bit in both registers forms a single host interrupt.

The bus is a write-enable plus word address. A write takes effect at the clock edge where `busWrEn` is high. Read data is combinational on `busAddr`. Word address 0 is the control word, 1 is the flag-return register, 2 is the programmable-flag-return register, and 3 reads 0 and ignores writes.

Top module: `cop_ipc_ctrl`

## Requirements
- R1: After reset, `copReset` is 2'b11, every other output is 0, the control word reads 0x0200_0200 and both return registers read 0.
- R2: A control write with bit 4 (coprocessor 0) or bit 20 (coprocessor 1) set inverts that `copEdgeIrq` line at the write edge. A 0 in that bit leaves the line unchanged. The bit reads back as the current line state.
- R3: Control bits 3 and 19 drive `copLevelIrq[0]` and `copLevelIrq[1]`, taking the written value at the write edge.
- R4: Control bits 0, 1, 16 and 17 drive `copPflagIrq[0..3]`. Bits 7 and 23 drive `copPwrDnReq`. Bits 9 and 25 drive `copReset`. All of these are active high and read back as written.
- R5: Control bits 8 and 24 read the power-down acknowledge inputs after a two-flop synchronizer, so an input change shows up after two clock edges. Writes to these two bits are ignored.
- R6: In the control word, every bit other than 0, 1, 3, 4, 7, 8, 9, 16, 17, 19, 20, 23, 24, 25, 30 and 31 reads 0 and ignores writes. Word address 3 reads 0.
- R7: In the flag-return register (address 1), bit 0 is coprocessor 0 flag 0, bit 8 is coprocessor 0 flag 1, bit 16 is coprocessor 1 flag 0 and bit 24 is coprocessor 1 flag 1. These bits are driven by `copFlagIn[0..3]` in that order. A bit sets on the third clock edge after its input becomes active, and every other bit reads 0.
- R8: The programmable-flag-return register (address 2) uses the same layout and timing as R7, driven by `copPfRetIn[0..3]`.
- R9: Writing 1 to a return bit clears it and writing 0 has no effect. If the synchronized condition is still active in the same cycle, setting wins over clearing.
- R10: Control bit 30 sets the polarity for coprocessor 0 and bit 31 sets it for coprocessor 1. With 0 a flag is active high, and with 1 it is active low.
- R11: `hostIrq` is high exactly when any bit in either return register is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Word address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr` |
| copPwrDnAck | input | 2 | Power-down acknowledge from each coprocessor |
| copFlagIn | input | 4 | Flag returns: coprocessor c, flag k at index 2c+k |
| copPfRetIn | input | 4 | Programmable-flag returns, same indexing |
| copReset | output | 2 | Reset for each coprocessor, active high |
| copPwrDnReq | output | 2 | Power-down request, active high |
| copEdgeIrq | output | 2 | Toggle-type interrupt lines |
| copLevelIrq | output | 2 | Level-type interrupt lines |
| copPflagIrq | output | 4 | Programmable-flag interrupts, index 2c+k |
| hostIrq | output | 1 | Combined return-flag interrupt to the host |

## Verification
The edge line keeps its state across writes, so one missed or extra toggle leaves it inverted from then on. That error shows in the next control readback and in every later write that compares the line against the bench's toggle count. A sticky bit that is set wrongly or cleared wrongly shows up in `hostIrq` right away and in the return register on the next read. An error in synchronizer depth shifts the first cycle at which a return bit reads 1, and the bench samples that cycle and the one before it.

// File: rtl/cop_ipc_pkg.sv
package cop_ipc_pkg;
  localparam int DATA_W        = 32;
  localparam int ADDR_W        = 2;
  localparam int NUM_COP       = 2;
  localparam int FLAGS_PER_COP = 2;
  localparam int NUM_FLAGS     = NUM_COP * FLAGS_PER_COP;
  localparam int LANE_W        = 16;
  localparam int FLAG_STRIDE   = 8;

  // control word bit positions within one coprocessor lane
  localparam int PF_LSB    = 0;
  localparam int LVL_BIT   = 3;
  localparam int EDGE_BIT  = 4;
  localparam int PDREQ_BIT = 7;
  localparam int PDACK_BIT = 8;
  localparam int RST_BIT   = 9;
  localparam int POL_BASE  = 30;

  // plain read/write bits of the control word and their reset value
  localparam logic [DATA_W-1:0] CTL_RW_MASK = 32'hC28B_028B;
  localparam logic [DATA_W-1:0] CTL_RST_VAL = 32'h0200_0200;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTL   = 2'd0,
    REG_FLAG  = 2'd1,
    REG_PFRET = 2'd2,
    REG_NONE  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrCtl;
    logic    clrFlag;
    logic    clrPfRet;
    regSel_e rdSel;
  } strobe_t;

  function automatic int retPos(input int f);
    return (f / FLAGS_PER_COP) * LANE_W + (f % FLAGS_PER_COP) * FLAG_STRIDE;
  endfunction
endpackage

// File: rtl/cop_ipc_decode.sv
module cop_ipc_decode
  import cop_ipc_pkg::*;
(
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  regSel_e sel;

  always_comb begin
    sel            = regSel_e'(busAddr);
    strb.rdSel     = sel;
    strb.wrCtl     = busWrEn && (sel == REG_CTL);
    strb.clrFlag   = busWrEn && (sel == REG_FLAG);
    strb.clrPfRet  = busWrEn && (sel == REG_PFRET);
  end
endmodule

// File: rtl/cop_ipc_sync.sv
module cop_ipc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cop_ipc_datapath.sv
module cop_ipc_datapath
  import cop_ipc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_COP-1:0]   ackIn,
  input  logic [NUM_FLAGS-1:0] flagIn,
  input  logic [NUM_FLAGS-1:0] pfIn,
  output logic [NUM_COP-1:0]   copReset,
  output logic [NUM_COP-1:0]   copPwrDnReq,
  output logic [NUM_COP-1:0]   copEdgeIrq,
  output logic [NUM_COP-1:0]   copLevelIrq,
  output logic [NUM_FLAGS-1:0] copPflagIrq,
  output logic [DATA_W-1:0]    rdData,
  output logic                 hostIrq
);
  logic [DATA_W-1:0]    ctlQ;
  logic [NUM_COP-1:0]   edgeQ;
  logic [NUM_COP-1:0]   ackSync;
  logic [NUM_FLAGS-1:0] flagSync, pfSync;
  logic [NUM_FLAGS-1:0] flagSt, pfSt;
  logic [NUM_FLAGS-1:0] flagHit, pfHit;
  logic [DATA_W-1:0]    ctlWord, flagWord, pfWord;

  // plain read/write control bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ctlQ <= CTL_RST_VAL;
    else if (strb.wrCtl) ctlQ <= wrData & CTL_RW_MASK;
  end

  // toggle-on-one edge lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeQ <= '0;
    else begin
      for (int c = 0; c < NUM_COP; c++) begin
        if (strb.wrCtl && wrData[c*LANE_W+EDGE_BIT]) edgeQ[c] <= ~edgeQ[c];
      end
    end
  end

  cop_ipc_sync #(.WIDTH(NUM_COP),   .STAGES(SYNC_STAGES)) u_ackSync
    (.clk(clk), .rstN(rstN), .d(ackIn),  .q(ackSync));
  cop_ipc_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_flagSync
    (.clk(clk), .rstN(rstN), .d(flagIn), .q(flagSync));
  cop_ipc_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_pfSync
    (.clk(clk), .rstN(rstN), .d(pfIn),   .q(pfSync));

  // polarity-adjusted set conditions per return flag
  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_hit
    localparam int COP = f / FLAGS_PER_COP;
    assign flagHit[f] = flagSync[f] ^ ctlQ[POL_BASE+COP];
    assign pfHit[f]   = pfSync[f]   ^ ctlQ[POL_BASE+COP];
  end

  // sticky return bits: write-one clears, set wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagSt <= '0;
      pfSt   <= '0;
    end else begin
      for (int f = 0; f < NUM_FLAGS; f++) begin
        flagSt[f] <= (flagSt[f] & ~(strb.clrFlag  & wrData[retPos(f)])) | flagHit[f];
        pfSt[f]   <= (pfSt[f]   & ~(strb.clrPfRet & wrData[retPos(f)])) | pfHit[f];
      end
    end
  end

  // output mapping
  for (genvar c = 0; c < NUM_COP; c++) begin : g_cop
    localparam int BASE = c * LANE_W;
    assign copReset[c]    = ctlQ[BASE+RST_BIT];
    assign copPwrDnReq[c] = ctlQ[BASE+PDREQ_BIT];
    assign copLevelIrq[c] = ctlQ[BASE+LVL_BIT];
    assign copEdgeIrq[c]  = edgeQ[c];
    for (genvar k = 0; k < FLAGS_PER_COP; k++) begin : g_pf
      assign copPflagIrq[c*FLAGS_PER_COP+k] = ctlQ[BASE+PF_LSB+k];
    end
  end

  // readback words
  always_comb begin
    ctlWord  = ctlQ;
    flagWord = '0;
    pfWord   = '0;
    for (int c = 0; c < NUM_COP; c++) begin
      ctlWord[c*LANE_W+EDGE_BIT]  = edgeQ[c];
      ctlWord[c*LANE_W+PDACK_BIT] = ackSync[c];
    end
    for (int f = 0; f < NUM_FLAGS; f++) begin
      flagWord[retPos(f)] = flagSt[f];
      pfWord[retPos(f)]   = pfSt[f];
    end
  end

  always_comb begin
    case (strb.rdSel)
      REG_CTL:   rdData = ctlWord;
      REG_FLAG:  rdData = flagWord;
      REG_PFRET: rdData = pfWord;
      default:   rdData = '0;
    endcase
  end

  assign hostIrq = |{flagSt, pfSt};
endmodule

// File: rtl/cop_ipc_ctrl.sv
module cop_ipc_ctrl
  import cop_ipc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [1:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic [1:0]  copPwrDnAck,
  input  logic [3:0]  copFlagIn,
  input  logic [3:0]  copPfRetIn,
  output logic [1:0]  copReset,
  output logic [1:0]  copPwrDnReq,
  output logic [1:0]  copEdgeIrq,
  output logic [1:0]  copLevelIrq,
  output logic [3:0]  copPflagIrq,
  output logic        hostIrq
);
  strobe_t strb;

  cop_ipc_decode u_decode (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .strb    (strb)
  );

  cop_ipc_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (busWrData),
    .ackIn       (copPwrDnAck),
    .flagIn      (copFlagIn),
    .pfIn        (copPfRetIn),
    .copReset    (copReset),
    .copPwrDnReq (copPwrDnReq),
    .copEdgeIrq  (copEdgeIrq),
    .copLevelIrq (copLevelIrq),
    .copPflagIrq (copPflagIrq),
    .rdData      (busRdData),
    .hostIrq     (hostIrq)
  );
endmodule

// File: rtl/cop_ipc_ctrl_chk.sv
module cop_ipc_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrCtl,
  input logic        isCtlRd,
  input logic        isFlagRd,
  input logic [5:0]  wrBits,   // {rst1, edge1, lvl1, rst0, edge0, lvl0}
  input logic [31:0] rdData,
  input logic [1:0]  copEdgeIrq,
  input logic [1:0]  copLevelIrq,
  input logic [1:0]  copReset,
  input logic        hostIrq
);
  AST_EDGE_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    wrCtl |=> copEdgeIrq == ($past(copEdgeIrq) ^ {$past(wrBits[4]), $past(wrBits[1])})); // R2
  AST_EDGE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !wrCtl |=> $stable(copEdgeIrq)); // R2
  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    wrCtl |=> copLevelIrq == {$past(wrBits[3]), $past(wrBits[0])}); // R3
  AST_RESET_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    wrCtl |=> copReset == {$past(wrBits[5]), $past(wrBits[2])}); // R4
  AST_CTL_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    isCtlRd |-> (rdData & 32'h3C64_FC64) == 32'h0); // R6
  AST_FLAG_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    isFlagRd |-> (rdData & 32'hFEFE_FEFE) == 32'h0); // R7
  AST_HOST_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (isFlagRd && rdData != 32'h0) |-> hostIrq); // R11
endmodule

bind cop_ipc_ctrl cop_ipc_ctrl_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrCtl       (busWrEn && busAddr == 2'd0),
  .isCtlRd     (busAddr == 2'd0),
  .isFlagRd    (busAddr == 2'd1),
  .wrBits      ({busWrData[25], busWrData[20], busWrData[19],
                 busWrData[9], busWrData[4], busWrData[3]}),
  .rdData      (busRdData),
  .copEdgeIrq  (copEdgeIrq),
  .copLevelIrq (copLevelIrq),
  .copReset    (copReset),
  .hostIrq     (hostIrq)
);

// File: tb/sim_cop_ipc_ctrl.sv
`timescale 1ns/1ps
module sim_cop_ipc_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWrData = 32'h0;
  logic [31:0] busRdData;
  logic [1:0]  copPwrDnAck = 2'b00;
  logic [3:0]  copFlagIn = 4'h0;
  logic [3:0]  copPfRetIn = 4'h0;
  logic [1:0]  copReset, copPwrDnReq, copEdgeIrq, copLevelIrq;
  logic [3:0]  copPflagIrq;
  logic        hostIrq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  cop_ipc_ctrl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one write, applied at the posedge between two falling edges
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = 32'h0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 reset", {30'h0, copReset}, 32'h3);
    chk("R1 pwrdn", {30'h0, copPwrDnReq}, 32'h0);
    chk("R1 irqs", {24'h0, copPflagIrq, copLevelIrq, copEdgeIrq}, 32'h0);
    chk("R1 hostIrq", {31'h0, hostIrq}, 32'h0);
    rd(2'd0, v); chk("R1 ctl word", v, 32'h0200_0200);
    rd(2'd1, v); chk("R1 flag word", v, 32'h0);
    rd(2'd2, v); chk("R1 pfret word", v, 32'h0);
  endtask

  task automatic t_level_pflag();
    logic [31:0] v;
    wr(2'd0, 32'h0009_0203);
    chk("R4 pflag", {28'h0, copPflagIrq}, 32'h7);
    chk("R3 level", {30'h0, copLevelIrq}, 32'h2);
    chk("R4 reset", {30'h0, copReset}, 32'h1);
    chk("R2 edge untouched", {30'h0, copEdgeIrq}, 32'h0);
    rd(2'd0, v); chk("R4 ctl readback", v, 32'h0009_0203);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0010);
    chk("R2 toggle cop0", {30'h0, copEdgeIrq}, 32'h1);
    chk("R3 level cleared", {30'h0, copLevelIrq}, 32'h0);
    rd(2'd0, v); chk("R2 readback", v, 32'h0000_0010);
    wr(2'd0, 32'h0010_0010);
    chk("R2 toggle both", {30'h0, copEdgeIrq}, 32'h2);
    wr(2'd0, 32'h0);
    chk("R2 zero no effect", {30'h0, copEdgeIrq}, 32'h2);
    rd(2'd0, v); chk("R2 readback held", v, 32'h0010_0000);
  endtask

  task automatic t_all_ones();
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R6 R5 reserved and ack ignored", v, 32'hC28B_029B);
    chk("R4 pwrdn", {30'h0, copPwrDnReq}, 32'h3);
    chk("R2 toggle from 10", {30'h0, copEdgeIrq}, 32'h1);
    rd(2'd3, v); chk("R6 address 3", v, 32'h0);
    copPwrDnAck = 2'b10;
    edges(1);
    rd(2'd0, v); chk("R5 ack latency", v, 32'hC28B_029B);
    edges(1);
    rd(2'd0, v); chk("R5 ack visible", v, 32'hC38B_029B);
    // polarity 1 with idle-low inputs: every return flag is active
    rd(2'd1, v); chk("R10 active low flags", v, 32'h0101_0101);
    rd(2'd2, v); chk("R10 active low pfret", v, 32'h0101_0101);
    chk("R11 hostIrq set", {31'h0, hostIrq}, 32'h1);
    copPwrDnAck = 2'b00;
    wr(2'd0, 32'h0);
    chk("R2 edges kept", {30'h0, copEdgeIrq}, 32'h1);
    edges(3);
    wr(2'd1, 32'h0000_0001);
    rd(2'd1, v); chk("R9 w1c single", v, 32'h0101_0100);
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R9 write zero", v, 32'h0101_0100);
    wr(2'd1, 32'hFFFF_FFFF);
    chk("R11 still pending", {31'h0, hostIrq}, 32'h1);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R9 flags cleared", v, 32'h0);
    rd(2'd2, v); chk("R9 pfret cleared", v, 32'h0);
    chk("R11 hostIrq clear", {31'h0, hostIrq}, 32'h0);
  endtask

  task automatic t_return_flags();
    logic [31:0] v;
    @(negedge clk);
    copFlagIn = 4'b0001;
    edges(2);
    rd(2'd1, v); chk("R7 two edges", v, 32'h0);
    edges(1);
    rd(2'd1, v); chk("R7 third edge", v, 32'h0000_0001);
    chk("R11 follows flag", {31'h0, hostIrq}, 32'h1);
    wr(2'd1, 32'h0000_0001);
    rd(2'd1, v); chk("R9 set wins", v, 32'h0000_0001);
    copFlagIn = 4'b0000;
    edges(3);
    wr(2'd1, 32'h0000_0001);
    rd(2'd1, v); chk("R9 cleared after drop", v, 32'h0);
    copPfRetIn = 4'b1000;
    edges(2);
    rd(2'd2, v); chk("R8 two edges", v, 32'h0);
    edges(1);
    rd(2'd2, v); chk("R8 cop1 flag1", v, 32'h0100_0000);
    rd(2'd1, v); chk("R7 untouched", v, 32'h0);
    copPfRetIn = 4'b0000;
    edges(3);
    wr(2'd2, 32'h0100_0000);
    chk("R11 drops", {31'h0, hostIrq}, 32'h0);
  endtask

  task automatic t_polarity();
    logic [31:0] v;
    wr(2'd0, 32'h8000_0000);
    edges(2);
    rd(2'd1, v); chk("R10 cop1 only flags", v, 32'h0101_0000);
    rd(2'd2, v); chk("R10 cop1 only pfret", v, 32'h0101_0000);
    rd(2'd0, v); chk("R10 polarity readback", v, 32'h8000_0010);
    chk("R11 polarity irq", {31'h0, hostIrq}, 32'h1);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    edges(2);
    #1 rstN = 1'b1;
    edges(1);
    t_reset();
    t_level_pflag();
    t_edge();
    t_all_ones();
    t_return_flags();
    t_polarity();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule